// File: doc/BRIEF.md
# Keyed Diagnostic Write Unlock

This block protects a diagnostic control register from stray host writes. The register can start a full adapter reset, so its write port stays closed until the host has written an exact six-value key series, in order, to a separate key register. Once the series is complete, the diagnostic register accepts writes and reports that it is open. It then stays open until the host writes to the key register again.

The diagnostic register holds two controls. One starts a timed adapter reset that clears itself. The other holds the device in reset until the host releases it. Starting an adapter reset also sets the hold, so the host must clear it. A 4-bit device state output, which is also readable on the bus, shows "in reset" (0) while either control keeps the device down and "ready" (1) otherwise. The host reaches the block through a simple single-cycle register bus: a write strobe, a word address, write data, and read data from a combinational read.

Top module: `kdu_diag_unlock`

## Requirements
- R1: After reset the block is locked, the diagnostic register (word address 2) reads 0x0000_0000, the status register (word address 0) reads 1 in bits [3:0], and `devState` is 1 (ready).
- R2: Writing 0xF, 0x4, 0xB, 0x2, 0x7, 0xD as full 32-bit values, in that order, to the key register (word address 1) unlocks the block. From the cycle after the last write, diagnostic bit 7 reads 1.
- R3: Writing 0 to the key register while locked discards any partial series. Writing the remaining keys afterwards does not unlock.
- R4: While locked, any key write that does not match the next expected value restarts the series. A mismatching 0xF is taken as the first key of a new series.
- R5: While locked, writes to the diagnostic register change neither its contents nor `devState`, and they start no reset.
- R6: While unlocked, writing diagnostic bit 2 = 1 with no reset in progress starts an adapter reset. Bit 2 then reads 1 for exactly RESET_CYCLES clock cycles, beginning in the cycle after the write, and then clears by itself.
- R7: Starting an adapter reset sets diagnostic bit 1 (hold) regardless of the written value. `devState` returns to 1 only when the reset has finished and the host has written bit 1 = 0. While the reset is in progress `devState` is 0, even if the hold is already clear.
- R8: While unlocked, any write to the key register locks the block again. Bit 7 reads 0 from the next cycle, and later diagnostic writes are ignored. If that write is 0xF, it also counts as the first key of a new series.
- R9: While unlocked and with no reset in progress, writing diagnostic bit 1 = 1 makes `devState` 0 and writing bit 1 = 0 makes it 1. The bit reads back as written.
- R10: A diagnostic write made while a reset is in progress neither cancels nor lengthens the reset, whatever value it carries in bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regWrEn | input | 1 | Write strobe, one write per cycle |
| regAddr | input | ADDR_W | Word address: 0 status, 1 key, 2 diagnostic |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr` (combinational) |
| devState | output | 4 | Device state: 0 in reset, 1 ready |

## Verification
The hardest condition to reach is a diagnostic write that arrives while a reset is already counting down. The stimulus must first complete the key series, then start a reset, then place further diagnostic writes at known cycle offsets inside the window. The duration is then measured by counting the cycles in which bit 2 reads back set. The key matcher is driven by a table of key writes that covers the following cases:
- interleaved restarts,
- a flush in the middle of a series,
- a wrong final key,
- relocking with 0xF.

The expected unlock flag is checked after every write.

// File: rtl/kdu_pkg.sv
package kdu_pkg;

  localparam int KEY_LEN = 6;
  localparam logic [31:0] KEY_FIRST = 32'h0000_000F;

  localparam int DIAG_UNLOCK_BIT = 7;
  localparam int DIAG_RESET_BIT  = 2;
  localparam int DIAG_HOLD_BIT   = 1;

  localparam logic [3:0] STATE_IN_RESET = 4'h0;
  localparam logic [3:0] STATE_READY    = 4'h1;

  typedef struct packed {
    logic holdLoad;
    logic holdForce;
    logic holdValue;
    logic unlocked;
    logic resetBusy;
  } ctrl_strobe_t;

  function automatic logic [31:0] keyValue(input int unsigned idx);
    logic [31:0] v;
    case (idx)
      0: v = 32'h0000_000F;
      1: v = 32'h0000_0004;
      2: v = 32'h0000_000B;
      3: v = 32'h0000_0002;
      4: v = 32'h0000_0007;
      5: v = 32'h0000_000D;
      default: v = 32'hFFFF_FFFF;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/kdu_ctrl.sv
module kdu_ctrl
  import kdu_pkg::*;
#(
  parameter int ADDR_W       = 2,
  parameter int RESET_CYCLES = 16,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 1,
  parameter logic [ADDR_W-1:0] DIAG_ADDR = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output ctrl_strobe_t      strobe
);

  localparam int IDX_W = $clog2(KEY_LEN + 1);
  localparam int CNT_W = $clog2(RESET_CYCLES + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(KEY_LEN - 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RESET_CYCLES);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [IDX_W-1:0] keyIdx;
  logic             unlocked;
  logic             resetBusy;
  logic [CNT_W-1:0] resetCnt;

  logic keyWr;
  logic diagWr;
  logic keyMatch;
  logic isFirstKey;
  logic startReset;

  assign keyWr      = regWrEn && (regAddr == KEY_ADDR);
  assign diagWr     = regWrEn && (regAddr == DIAG_ADDR);
  assign keyMatch   = (regWdata == keyValue(int'(keyIdx)));
  assign isFirstKey = (regWdata == KEY_FIRST);
  assign startReset = diagWr && unlocked && regWdata[DIAG_RESET_BIT] && !resetBusy;

  // Key matcher and lock flag
  always_ff @(posedge clk) begin
    if (rst) begin
      keyIdx   <= '0;
      unlocked <= 1'b0;
    end else if (keyWr) begin
      if (unlocked) begin
        unlocked <= 1'b0;
        keyIdx   <= isFirstKey ? IDX_W'(1) : '0;
      end else if (keyMatch) begin
        if (keyIdx == LAST_IDX) begin
          unlocked <= 1'b1;
          keyIdx   <= '0;
        end else begin
          keyIdx <= keyIdx + IDX_W'(1);
        end
      end else begin
        keyIdx <= isFirstKey ? IDX_W'(1) : '0;
      end
    end
  end

  // Self-clearing adapter reset timer
  always_ff @(posedge clk) begin
    if (rst) begin
      resetBusy <= 1'b0;
      resetCnt  <= '0;
    end else if (startReset) begin
      resetBusy <= 1'b1;
      resetCnt  <= CNT_LOAD;
    end else if (resetBusy) begin
      if (resetCnt == CNT_ONE) begin
        resetBusy <= 1'b0;
        resetCnt  <= '0;
      end else begin
        resetCnt <= resetCnt - CNT_ONE;
      end
    end
  end

  always_comb begin
    strobe.holdLoad  = diagWr && unlocked;
    strobe.holdForce = startReset;
    strobe.holdValue = regWdata[DIAG_HOLD_BIT];
    strobe.unlocked  = unlocked;
    strobe.resetBusy = resetBusy;
  end

  // R2: unlocking only follows a write of the final key
  assert_unlock_last_key_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> ($past(keyWr) && $past(regWdata) == keyValue(KEY_LEN - 1)));

  // R6: a started reset runs with a full count
  assert_reset_load_R6: assert property (@(posedge clk) disable iff (rst)
    startReset |=> (resetBusy && resetCnt == CNT_LOAD));

  // R6: the reset ends only when the count is exhausted
  assert_reset_end_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(resetBusy) |-> ($past(resetCnt) == CNT_ONE));

  // R10: a diagnostic write during a reset neither reloads nor stops it early
  assert_no_restart_R10: assert property (@(posedge clk) disable iff (rst)
    (diagWr && resetBusy && resetCnt != CNT_ONE) |=>
      (resetBusy && resetCnt == $past(resetCnt) - CNT_ONE));

endmodule

// File: rtl/kdu_datapath.sv
module kdu_datapath
  import kdu_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 0,
  parameter logic [ADDR_W-1:0] DIAG_ADDR   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_strobe_t      strobe,
  input  logic [ADDR_W-1:0] regAddr,
  output logic [31:0]       regRdata,
  output logic [3:0]        devState
);

  logic holdBit;
  logic [31:0] diagWord;

  always_ff @(posedge clk) begin
    if (rst) begin
      holdBit <= 1'b0;
    end else if (strobe.holdForce) begin
      holdBit <= 1'b1;
    end else if (strobe.holdLoad) begin
      holdBit <= strobe.holdValue;
    end
  end

  assign devState = (holdBit || strobe.resetBusy) ? STATE_IN_RESET : STATE_READY;

  always_comb begin
    diagWord = '0;
    diagWord[DIAG_UNLOCK_BIT] = strobe.unlocked;
    diagWord[DIAG_RESET_BIT]  = strobe.resetBusy;
    diagWord[DIAG_HOLD_BIT]   = holdBit;
  end

  always_comb begin
    if (regAddr == STATUS_ADDR) begin
      regRdata = {28'h0, devState};
    end else if (regAddr == DIAG_ADDR) begin
      regRdata = diagWord;
    end else begin
      regRdata = '0;
    end
  end

  // R7: a reset start always leaves the hold set
  assert_hold_on_start_R7: assert property (@(posedge clk) disable iff (rst)
    strobe.holdForce |=> (holdBit && devState == STATE_IN_RESET));

  // R5: without a load strobe the hold cannot move except by a reset start
  assert_hold_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (!strobe.holdLoad && !strobe.holdForce) |=> $stable(holdBit));

endmodule

// File: rtl/kdu_diag_unlock.sv
module kdu_diag_unlock
  import kdu_pkg::*;
#(
  parameter int ADDR_W       = 2,
  parameter int RESET_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic [3:0]        devState
);

  localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] KEY_ADDR    = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] DIAG_ADDR   = ADDR_W'(2);

  ctrl_strobe_t strobe;

  kdu_ctrl #(
    .ADDR_W      (ADDR_W),
    .RESET_CYCLES(RESET_CYCLES),
    .KEY_ADDR    (KEY_ADDR),
    .DIAG_ADDR   (DIAG_ADDR)
  ) ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .regWdata(regWdata),
    .strobe  (strobe)
  );

  kdu_datapath #(
    .ADDR_W     (ADDR_W),
    .STATUS_ADDR(STATUS_ADDR),
    .DIAG_ADDR  (DIAG_ADDR)
  ) dp_i (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .regAddr (regAddr),
    .regRdata(regRdata),
    .devState(devState)
  );

  // R5: a locked diagnostic write with no reset running leaves the state alone
  assert_locked_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && regAddr == DIAG_ADDR && !strobe.unlocked && !strobe.resetBusy)
      |=> ($stable(devState) && !strobe.resetBusy));

  // R8: a key write while open closes the register
  assert_relock_R8: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && regAddr == KEY_ADDR && strobe.unlocked) |=> !strobe.unlocked);

endmodule

// File: tb/kdu_diag_unlock_tb_top.sv
`timescale 1ns/1ps
module kdu_diag_unlock_tb_top;

  localparam int ADDR_W = 2;
  localparam int RST_N  = 12;
  localparam logic [1:0] A_STAT = 2'd0;
  localparam logic [1:0] A_KEY  = 2'd1;
  localparam logic [1:0] A_DIAG = 2'd2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic regWrEn = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [3:0]  devState;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  kdu_diag_unlock #(.ADDR_W(ADDR_W), .RESET_CYCLES(RST_N)) dut_i (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .devState(devState)
  );

  // {key byte, expected unlock flag after the write}
  localparam int NV = 30;
  localparam logic [8:0] VEC [NV] = '{
    {8'h0F,1'b0},{8'h04,1'b0},{8'h0B,1'b0},{8'h02,1'b0},{8'h07,1'b0},{8'h0D,1'b1}, // R2
    {8'h0F,1'b0},{8'h04,1'b0},{8'h00,1'b0},{8'h0B,1'b0},{8'h02,1'b0},{8'h07,1'b0},
    {8'h0D,1'b0},                                                                  // R8 then R3
    {8'h0F,1'b0},{8'h04,1'b0},{8'h0F,1'b0},{8'h04,1'b0},{8'h0B,1'b0},{8'h02,1'b0},
    {8'h07,1'b0},{8'h0D,1'b1},                                                     // R4
    {8'h05,1'b0},                                                                  // R8
    {8'h0F,1'b0},{8'h04,1'b0},{8'h0B,1'b0},{8'h02,1'b0},{8'h07,1'b0},{8'h03,1'b0},
    {8'h0D,1'b0},{8'h0D,1'b0}                                                      // R4
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrEn = 1'b0; regWdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #0.5;
    d = regRdata;
  endtask

  task automatic unlockSeq();
    wr(A_KEY, 32'hF); wr(A_KEY, 32'h4); wr(A_KEY, 32'hB);
    wr(A_KEY, 32'h2); wr(A_KEY, 32'h7); wr(A_KEY, 32'hD);
  endtask

  task automatic countBusy(output int n);
    logic [31:0] d;
    n = 0;
    rd(A_DIAG, d);
    while (d[2] && n < 1000) begin
      n++;
      @(negedge clk);
      rd(A_DIAG, d);
    end
  endtask

  initial begin
    #20000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(A_DIAG, d); check("R1 diag", d, 32'h0);
    rd(A_STAT, d); check("R1 status", d, 32'h1);
    check("R1 devState", {28'h0, devState}, 32'h1);

    // key matcher table
    for (int i = 0; i < NV; i++) begin
      wr(A_KEY, {24'h0, VEC[i][8:1]});
      rd(A_DIAG, d);
      check($sformatf("R2/R3/R4/R8 vec %0d", i), {31'h0, d[7]}, {31'h0, VEC[i][0]});
    end

    // R5: locked diagnostic writes ignored
    wr(A_DIAG, 32'h6);
    rd(A_DIAG, d); check("R5 diag", d, 32'h0);
    check("R5 state", {28'h0, devState}, 32'h1);
    repeat (RST_N + 2) @(negedge clk);
    rd(A_DIAG, d); check("R5 no reset", d, 32'h0);

    // R9: direct hold control
    unlockSeq();
    rd(A_DIAG, d); check("R2 open", d, 32'h80);
    wr(A_DIAG, 32'h2);
    rd(A_DIAG, d); check("R9 hold set", d, 32'h82);
    check("R9 state0", {28'h0, devState}, 32'h0);
    wr(A_DIAG, 32'h0);
    rd(A_DIAG, d); check("R9 hold clr", d, 32'h80);
    check("R9 state1", {28'h0, devState}, 32'h1);

    // R6/R7: timed reset
    wr(A_DIAG, 32'h4);
    rd(A_DIAG, d); check("R7 hold forced", {31'h0, d[1]}, 32'h1);
    check("R6 state busy", {28'h0, devState}, 32'h0);
    countBusy(n);
    check("R6 duration", n, RST_N);
    rd(A_DIAG, d); check("R7 hold kept", d, 32'h82);
    check("R7 still held", {28'h0, devState}, 32'h0);
    wr(A_DIAG, 32'h0);
    check("R7 ready", {28'h0, devState}, 32'h1);

    // R10: clearing write inside window
    wr(A_DIAG, 32'h4);
    repeat (3) @(negedge clk);
    wr(A_DIAG, 32'h0);
    check("R7 busy hold clr", {28'h0, devState}, 32'h0);
    countBusy(n);
    check("R10 no cancel", n, RST_N - 4);
    check("R7 ready after", {28'h0, devState}, 32'h1);

    // R10: re-request inside window
    wr(A_DIAG, 32'h4);
    repeat (5) @(negedge clk);
    wr(A_DIAG, 32'h4);
    countBusy(n);
    check("R10 no extend", n, RST_N - 6);

    // R8: 0xF relocks, then diagnostic write ignored
    wr(A_DIAG, 32'h0);
    wr(A_KEY, 32'hF);
    rd(A_DIAG, d); check("R8 locked", d, 32'h0);
    wr(A_DIAG, 32'h2);
    rd(A_DIAG, d); check("R8 ignored", d, 32'h0);
    check("R8 state", {28'h0, devState}, 32'h1);
    // R8: the 0xF counted as first key
    wr(A_KEY, 32'h4); wr(A_KEY, 32'hB); wr(A_KEY, 32'h2);
    wr(A_KEY, 32'h7); wr(A_KEY, 32'hD);
    rd(A_DIAG, d); check("R8 first key", {31'h0, d[7]}, 32'h1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule